// File: doc/BRIEF.md
# Interleaved Screen Address Generator

This block turns the display timing counters into the byte address the video fetch engine reads from a 64K RAM. The screen occupies one 16K quarter of that RAM, chosen by the two most significant bits of a 14-bit start register. Inside the quarter, each of the eight raster lines of a character row lives in its own 2K block, so the raster line number selects the block directly. The position inside a block is the linear character count for the row and column, plus the start offset. That sum is doubled to a byte offset and folded modulo 2K, so a screen that runs past the end of a block wraps to the start of the same block.

Each character clock covers two bytes. The byte-phase input picks the even byte (phase 0) or the odd byte (phase 1) of the pair. The fetch engine drives the column counter (0 to 39), the row counter (0 to 24), the raster counter (0 to 7) and the phase. It receives the address one clock later from an output register.

Top module: `vma_addr_gen`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0x0000.
- R2: `mem_addr[15:14]` equals `start_addr[13:12]` as sampled at the previous clock edge. This selects bank 0x0000, 0x4000, 0x8000 or 0xC000.
- R3: `mem_addr[13:11]` equals the previous `line_cnt`, so raster line n of every row maps to 2K block n of the bank.
- R4: `mem_addr[0]` equals the previous `byte_sel`: 0 gives the even byte of a character pair and 1 gives the odd byte.
- R5: `mem_addr[10:1]` equals (`start_addr[9:0]` + 40*`row_cnt` + `col_cnt`) mod 1024, using the previous inputs.
- R6: An offset sum past 1023 wraps inside the same 2K block. The raster and bank fields are not carried into.
- R7: The output changes only at a clock edge, one cycle after the inputs it reflects.
- R8: `start_addr[11:10]` has no effect on `mem_addr`.
- R9: With the other inputs held, switching `byte_sel` from 0 to 1 makes the next address exactly one above the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-half clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 14 | Screen start register: bank in [13:12], word offset in [9:0] |
| col_cnt | input | 6 | Character column, 0 to 39 |
| row_cnt | input | 5 | Character row, 0 to 24 |
| line_cnt | input | 3 | Raster line within the character row, 0 to 7 |
| byte_sel | input | 1 | Byte of the character pair: 0 even, 1 odd |
| mem_addr | output | 16 | Registered RAM byte address |

## Verification
On every clock after reset, the bound checker compares each field of the registered address against the previous inputs: bank, raster block, phase bit and the folded word offset. It also checks that an even-to-odd phase step moves the address by exactly one. Only the bench scenarios can show two things. The first is that the start-register bits 11:10 leave the address untouched. The second is how the offset wraps at corners such as a start of 1023 or the last column of the last row. The bench also checks that the output holds its old value between the input change and the next edge.

// File: rtl/vma_pkg.sv
package vma_pkg;

   // Selects how the row-times-columns product is built.
   typedef enum logic [0:0] {
      MUL_OPERATOR  = 1'b0,
      MUL_SHIFT_ADD = 1'b1
   } mul_impl_e;

   // Default geometry of the screen area.
   localparam int DEF_ADDR_W     = 16;
   localparam int DEF_START_W    = 14;
   localparam int DEF_COL_W      = 6;
   localparam int DEF_ROW_W      = 5;
   localparam int DEF_RASTER_W   = 3;
   localparam int DEF_BLOCK_LOG2 = 11;
   localparam int DEF_COLS       = 40;

   // Bits needed to hold a constant value v.
   function automatic int bits_for(input int v);
      int n;
      n = 1;
      while ((1 << n) <= v) n++;
      return n;
   endfunction

endpackage

// File: rtl/vma_row_scale.sv
module vma_row_scale
   import vma_pkg::*;
#(
   parameter int        ROW_W    = DEF_ROW_W,
   parameter int        WORD_W   = 10,
   parameter int        COLS     = DEF_COLS,
   parameter mul_impl_e MUL_IMPL = MUL_SHIFT_ADD
) (
   input  logic [ROW_W-1:0]  row_i,
   output logic [WORD_W-1:0] scaled_o
);

   localparam int COLS_BITS = bits_for(COLS);
   localparam logic [WORD_W-1:0] COLS_W = WORD_W'(COLS);

   logic [WORD_W-1:0] row_ext;

   // Elaboration checks on the geometry.
   if (ROW_W > WORD_W) begin : g_chk_row
      $error("vma_row_scale: ROW_W wider than the word offset");
   end
   if (COLS < 1) begin : g_chk_cols
      $error("vma_row_scale: COLS must be positive");
   end

   assign row_ext = {{(WORD_W-ROW_W){1'b0}}, row_i};

   if (MUL_IMPL == MUL_OPERATOR) begin : g_oper
      // Let synthesis pick the constant multiplier structure.
      assign scaled_o = row_ext * COLS_W;
   end else begin : g_shift_add
      // One shifted copy of the row for every set bit of COLS, summed in turn.
      logic [WORD_W-1:0] terms [COLS_BITS];
      for (genvar i = 0; i < COLS_BITS; i++) begin : g_term
         if (((COLS >> i) & 1) != 0) begin : g_on
            assign terms[i] = row_ext << i;
         end else begin : g_off
            assign terms[i] = '0;
         end
      end
      always_comb begin
         scaled_o = '0;
         for (int k = 0; k < COLS_BITS; k++) begin
            scaled_o = scaled_o + terms[k];
         end
      end
   end

endmodule

// File: rtl/vma_word_offset.sv
module vma_word_offset #(
   parameter int WORD_W = 10,
   parameter int COL_W  = 6
) (
   input  logic [WORD_W-1:0] base_i,
   input  logic [WORD_W-1:0] row_scaled_i,
   input  logic [COL_W-1:0]  col_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] col_ext;

   if (COL_W >= WORD_W) begin : g_chk_col
      $error("vma_word_offset: COL_W must be narrower than WORD_W");
   end

   assign col_ext = {{(WORD_W-COL_W){1'b0}}, col_i};

   // Truncation to WORD_W bits is the wrap inside one block.
   assign word_o = base_i + row_scaled_i + col_ext;

endmodule

// File: rtl/vma_addr_compose.sv
module vma_addr_compose #(
   parameter int ADDR_W   = 16,
   parameter int BANK_W   = 2,
   parameter int RASTER_W = 3,
   parameter int WORD_W   = 10
) (
   input  logic [BANK_W-1:0]   bank_i,
   input  logic [RASTER_W-1:0] raster_i,
   input  logic [WORD_W-1:0]   word_i,
   input  logic                phase_i,
   output logic [ADDR_W-1:0]   addr_o
);

   if (BANK_W + RASTER_W + WORD_W + 1 != ADDR_W) begin : g_chk_fields
      $error("vma_addr_compose: fields do not fill the address");
   end

   // bank | raster block | word in block | byte of pair
   assign addr_o = {bank_i, raster_i, word_i, phase_i};

endmodule

// File: rtl/vma_addr_gen.sv
module vma_addr_gen
   import vma_pkg::*;
#(
   parameter int        ADDR_W     = DEF_ADDR_W,
   parameter int        START_W    = DEF_START_W,
   parameter int        COL_W      = DEF_COL_W,
   parameter int        ROW_W      = DEF_ROW_W,
   parameter int        RASTER_W   = DEF_RASTER_W,
   parameter int        BLOCK_LOG2 = DEF_BLOCK_LOG2,
   parameter int        COLS       = DEF_COLS,
   parameter mul_impl_e MUL_IMPL   = MUL_SHIFT_ADD
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [START_W-1:0]  start_addr,
   input  logic [COL_W-1:0]    col_cnt,
   input  logic [ROW_W-1:0]    row_cnt,
   input  logic [RASTER_W-1:0] line_cnt,
   input  logic                byte_sel,
   output logic [ADDR_W-1:0]   mem_addr
);

   localparam int WORD_W    = BLOCK_LOG2 - 1;
   localparam int AREA_LOG2 = BLOCK_LOG2 + RASTER_W;
   localparam int BANK_W    = ADDR_W - AREA_LOG2;

   if (BANK_W < 1) begin : g_chk_bank
      $error("vma_addr_gen: address too narrow for a bank field");
   end
   if (START_W < WORD_W + BANK_W) begin : g_chk_start
      $error("vma_addr_gen: start register cannot hold bank and offset");
   end
   if (COLS >= (1 << COL_W)) begin : g_chk_colw
      $error("vma_addr_gen: COL_W too narrow for COLS");
   end

   logic [WORD_W-1:0] row_scaled;
   logic [WORD_W-1:0] word_ofs;
   logic [ADDR_W-1:0] addr_next;
   logic [BANK_W-1:0] bank_sel;

   // Bits between the offset and the bank are intentionally unused.
   assign bank_sel = start_addr[START_W-1 -: BANK_W];

   vma_row_scale #(
      .ROW_W    (ROW_W),
      .WORD_W   (WORD_W),
      .COLS     (COLS),
      .MUL_IMPL (MUL_IMPL)
   ) u_row_scale (
      .row_i    (row_cnt),
      .scaled_o (row_scaled)
   );

   vma_word_offset #(
      .WORD_W (WORD_W),
      .COL_W  (COL_W)
   ) u_word_offset (
      .base_i       (start_addr[WORD_W-1:0]),
      .row_scaled_i (row_scaled),
      .col_i        (col_cnt),
      .word_o       (word_ofs)
   );

   vma_addr_compose #(
      .ADDR_W   (ADDR_W),
      .BANK_W   (BANK_W),
      .RASTER_W (RASTER_W),
      .WORD_W   (WORD_W)
   ) u_compose (
      .bank_i   (bank_sel),
      .raster_i (line_cnt),
      .word_i   (word_ofs),
      .phase_i  (byte_sel),
      .addr_o   (addr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_addr <= '0;
      else        mem_addr <= addr_next;
   end

endmodule

// File: rtl/vma_addr_gen_chk.sv
module vma_addr_gen_chk #(
   parameter int ADDR_W     = 16,
   parameter int START_W    = 14,
   parameter int COL_W      = 6,
   parameter int ROW_W      = 5,
   parameter int RASTER_W   = 3,
   parameter int BLOCK_LOG2 = 11,
   parameter int COLS       = 40
) (
   input logic                clk,
   input logic                rst_n,
   input logic [START_W-1:0]  start_addr,
   input logic [COL_W-1:0]    col_cnt,
   input logic [ROW_W-1:0]    row_cnt,
   input logic [RASTER_W-1:0] line_cnt,
   input logic                byte_sel,
   input logic [ADDR_W-1:0]   mem_addr
);

   localparam int WORD_W = BLOCK_LOG2 - 1;
   localparam int BANK_W = ADDR_W - BLOCK_LOG2 - RASTER_W;

   logic [1:0]        live;
   logic [WORD_W-1:0] ref_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         live <= 2'd0;
      else if (live != 3) live <= live + 2'd1;
   end

   assign ref_word = WORD_W'(32'(start_addr[WORD_W-1:0]) + 32'(row_cnt) * COLS
                             + 32'(col_cnt));

   always_comb begin
      if (!rst_n) p_reset_zero_r1: assert (mem_addr == '0);
   end

   p_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (live != 0) |-> mem_addr[ADDR_W-1 -: BANK_W] == $past(start_addr[START_W-1 -: BANK_W]));

   p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live != 0) |-> mem_addr[BLOCK_LOG2 +: RASTER_W] == $past(line_cnt));

   p_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (live != 0) |-> mem_addr[0] == $past(byte_sel));

   p_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live != 0) |-> mem_addr[WORD_W:1] == $past(ref_word));

   p_pair_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 3 && byte_sel && !$past(byte_sel) && $stable(start_addr) &&
       $stable(col_cnt) && $stable(row_cnt) && $stable(line_cnt))
      |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

endmodule

bind vma_addr_gen vma_addr_gen_chk #(
   .ADDR_W     (ADDR_W),
   .START_W    (START_W),
   .COL_W      (COL_W),
   .ROW_W      (ROW_W),
   .RASTER_W   (RASTER_W),
   .BLOCK_LOG2 (BLOCK_LOG2),
   .COLS       (COLS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_addr (start_addr),
   .col_cnt    (col_cnt),
   .row_cnt    (row_cnt),
   .line_cnt   (line_cnt),
   .byte_sel   (byte_sel),
   .mem_addr   (mem_addr)
);

// File: tb/vma_addr_gen_test.sv
module vma_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] start_addr = '0;
   logic [5:0]  col_cnt = '0;
   logic [4:0]  row_cnt = '0;
   logic [2:0]  line_cnt = '0;
   logic        byte_sel = 1'b0;
   logic [15:0] mem_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   typedef struct {
      logic [15:0] val;
      string       req;
   } exp_t;
   exp_t sb_q[$];
   logic [15:0] last_exp = '0;

   always #5 clk = ~clk;

   vma_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .col_cnt(col_cnt),
      .row_cnt(row_cnt), .line_cnt(line_cnt), .byte_sel(byte_sel),
      .mem_addr(mem_addr)
   );

   // Expected address from the requirements.
   function automatic logic [15:0] model(input logic [13:0] s, input int row,
                                         input int col, input int ras, input bit ph);
      int w;
      w = (int'(s[9:0]) + row * 40 + col) % 1024;
      return {s[13:12], 3'(ras), 10'(w), ph};
   endfunction

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: apply inputs at the falling edge, queue the expected result.
   task automatic drive(input logic [13:0] s, input int row, input int col,
                        input int ras, input bit ph, input string req);
      exp_t e;
      @(negedge clk);
      start_addr = s; row_cnt = 5'(row); col_cnt = 6'(col);
      line_cnt = 3'(ras); byte_sel = ph;
      #1;
      // R7: nothing changes before the next edge.
      check(mem_addr, last_exp, "R7 hold");
      e.val = model(s, row, col, ras, ph);
      e.req = req;
      sb_q.push_back(e);
      last_exp = e.val;
   endtask

   // Monitor: compare just after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(mem_addr, e.val, e.req);
         end
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, even with inputs active.
      start_addr = 14'h3FFF; row_cnt = 5'd3; col_cnt = 6'd7; line_cnt = 3'd5; byte_sel = 1'b1;
      repeat (3) @(posedge clk);
      #1 check(mem_addr, 16'h0000, "R1 reset");
      @(negedge clk);
      start_addr = '0; row_cnt = '0; col_cnt = '0; line_cnt = '0; byte_sel = 1'b0;
      #1 check(mem_addr, 16'h0000, "R1 reset");
      rst_n = 1'b1;

      // R2: each bank.
      for (int b = 0; b < 4; b++) drive(14'(b << 12), 0, 0, 0, 0, "R2 bank");
      // R3: each raster block.
      for (int r = 0; r < 8; r++) drive(14'h1000, 2, 3, r, 0, "R3 block");
      // R4/R9: even then odd byte of a pair.
      drive(14'h2010, 1, 5, 2, 0, "R4 even");
      drive(14'h2010, 1, 5, 2, 1, "R9 odd step");
      // R5: interior positions.
      drive(14'h0000, 1, 0, 0, 0, "R5 row stride");
      drive(14'h0123, 10, 17, 4, 1, "R5 offset");
      drive(14'h3000, 24, 39, 7, 1, "R5 last char");
      // R6: wrap inside the block.
      drive(14'h03FF, 0, 1, 3, 0, "R6 wrap start 1023");
      drive(14'h03E8, 24, 39, 6, 1, "R6 wrap far end");
      drive(14'h33FF, 0, 0, 7, 1, "R6 block top");
      // R8: bits 11:10 ignored.
      drive(14'h0C55, 2, 9, 1, 0, "R8 ignored bits");
      check(model(14'h0C55, 2, 9, 1, 0), model(14'h0055, 2, 9, 1, 0), "R8 model");
      drive(14'h0055, 2, 9, 1, 0, "R8 reference");
      // Walk a whole raster line, both bytes of each character.
      for (int c = 0; c < 40; c++) begin
         drive(14'h1200, 5, c, 3, 0, "R5 scan even");
         drive(14'h1200, 5, c, 3, 1, "R9 scan odd");
      end
      repeat (3) @(posedge clk);
      #2;
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule